// File: doc/BRIEF.md
# Pipelined Converter Digital Correction and Alignment

This block sits behind a nine-stage pipelined analog-to-digital converter. Stages one through eight each resolve a redundant 1.5-bit digit from a pair of comparators, and the ninth stage is a plain 2-bit flash. Because a sample moves one stage further down the analog pipeline on every half sample period, the nine digits belonging to one sample reach the digital side on nine consecutive half-period ticks. The block decodes each stage's comparator pattern, holds each digit back just long enough that all nine digits of a sample are present together, and then forms the output word by overlap-adding them with weights that halve from one stage to the next. An output latch holds the word for a full sample period.

The logic runs from one clock at twice the sample rate. A sample-enable input, high on every other tick, marks the ticks on which the analog front end samples. Redundancy in the 1.5-bit digits means that comparator thresholds may wander by up to a quarter of the reference without creating missing codes. A comparator pattern that a correct thermometer pair can never produce is still resolved to a digit, and the output word built from it is flagged.

Top module: `pipe_adc_corrector`

## Requirements
- R1: For stages 1 to 8 the 2-bit comparator pattern (bit 1 upper comparator, bit 0 lower comparator) decodes as 00 to digit 0, 01 to digit 1 and 11 to digit 2; the stage 9 input is taken as a binary digit 0 to 3.
- R2: The output word equals the sum over stages k = 1 to 8 of digit_k × 2^(9−k), plus the stage 9 digit; it spans exactly 0 to 1023 and never overflows 10 bits.
- R3: The sample enable is high on alternate ticks. For a sample taken at the tick-edge E where sample enable is high, stage k's pattern is captured at edge E+k (stage k bits sit at positions 2(k−1)+1 and 2(k−1) of the stage bus). The word for that sample appears on the output after edge E+10, five sample periods later; values on the stage inputs at any other edge do not reach the output.
- R4: The output word, valid flag and error flag change only at edges where sample enable is high, and hold on the ticks between.
- R5: The pattern 10 on any of stages 1 to 8 decodes as digit 1, and the error flag is high with exactly the output word built from it; a word with no such pattern has the error flag low.
- R6: After reset the valid flag stays low until the first sample taken after reset reaches the output (the sixth sample-enable edge), then stays high until the next reset.
- R7: A synchronous active-low reset clears the output word, valid flag and error flag to zero.
- R8: With each stage comparator threshold offset by up to a quarter of the reference, a slow full-scale ramp yields output words that never decrease and that reach every code from 0 to 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock at twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en_i | input | 1 | High on the tick where the front end samples; alternates |
| stg_cmp_i | input | 16 | Comparator pairs of stages 1 to 8, stage k at bits 2(k−1)+1:2(k−1) |
| flash_i | input | 2 | Binary digit from the final 2-bit flash stage |
| code_o | output | 10 | Corrected output word |
| valid_o | output | 1 | Output word belongs to a sample taken after reset |
| err_o | output | 1 | Output word was built from an impossible comparator pattern |

## Verification
A delay line one register too short or too long for any stage mixes digits of adjacent samples, which shows at the output as a wrong word as early as the first sample's arrival, ten ticks after the first sampling edge; the bench drives unrelated values on the stage buses during every tick that does not carry a sample's digit so that such a shift cannot hide. A wrong weight or decode shows as a wrong word on the directed patterns (all zero, all full, midscale, single-stage values) and as a break in the ramp's monotonic sweep. A fill counter that counts wrongly shows as the valid flag rising one sample period early or late.

// File: rtl/adc_corr_pkg.sv
// Shared types for the pipelined-converter correction logic.
// Assumes every stage digit fits in two bits.
package adc_corr_pkg;
    localparam int DIG_W = 2;           // bits per decoded stage digit
    localparam int CMP_W = 2;           // comparator outputs per redundant stage
    typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/pipe_digit_decode.sv
// Turns one stage's raw comparator pattern into a digit.
// Redundant stages use a thermometer pair; the final flash stage is already binary.
// Assumes raw_i is bit 1 = upper comparator, bit 0 = lower comparator.
module pipe_digit_decode
    import adc_corr_pkg::*;
#(
    parameter bit IS_FLASH = 1'b0
) (
    input  logic [CMP_W-1:0] raw_i,
    output digit_t           dig_o,
    output logic             bad_o
);
    generate
        if (IS_FLASH) begin : g_flash
            // Binary flash code passes straight through.
            always_comb begin
                dig_o = raw_i;
                bad_o = 1'b0;
            end
        end else begin : g_thermo
            // Thermometer decode; the impossible pattern resolves to the middle digit.
            always_comb begin
                unique case (raw_i)
                    2'b00:   begin dig_o = 2'd0; bad_o = 1'b0; end
                    2'b01:   begin dig_o = 2'd1; bad_o = 1'b0; end
                    2'b11:   begin dig_o = 2'd2; bad_o = 1'b0; end
                    default: begin dig_o = 2'd1; bad_o = 1'b1; end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/pipe_align_delay.sv
// Fixed-depth register chain that holds a stage's digit back until the
// digits of later stages for the same sample arrive.
// Assumes DEPTH >= 1; advances on every tick.
module pipe_align_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [DEPTH];

    // Shift the chain by one slot each tick; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/pipe_overlap_sum.sv
// Overlap-add of the aligned digits. Digit i (0 = first stage) carries
// weight 2^(NSTAGE-1-i); the final flash digit therefore has weight 1.
// Output is one bit wider than the code so range can be checked upstream.
module pipe_overlap_sum
    import adc_corr_pkg::*;
#(
    parameter int NSTAGE = 9,
    localparam int SUM_W = NSTAGE + 2
) (
    input  logic [DIG_W*NSTAGE-1:0] dig_i,
    output logic [SUM_W-1:0]        sum_o
);
    // Accumulate shifted digits.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            sum_o = sum_o + (SUM_W'(dig_i[DIG_W*i +: DIG_W]) << (NSTAGE - 1 - i));
        end
    end
endmodule

// File: rtl/pipe_adc_corrector.sv
// Digital correction and time alignment for a pipelined converter with
// NSTAGE-1 redundant 1.5-bit stages and one final 2-bit flash stage.
// Clock runs at twice the sample rate; samp_en_i marks sampling ticks and
// must alternate. Stage k's digit for a sample taken at edge E is captured
// at edge E+k; the corrected word is latched at edge E+NSTAGE+1.
// Assumes NSTAGE is odd so that the latch edge is itself a sampling edge.
module pipe_adc_corrector
    import adc_corr_pkg::*;
#(
    parameter int NSTAGE = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    samp_en_i,
    input  logic [CMP_W*(NSTAGE-1)-1:0] stg_cmp_i,
    input  logic [CMP_W-1:0]        flash_i,
    output logic [NSTAGE:0]         code_o,
    output logic                    valid_o,
    output logic                    err_o
);
    localparam int OUT_W = NSTAGE + 1;
    localparam int NRED  = NSTAGE - 1;
    localparam int LAT_S = (NSTAGE + 1) / 2;
    localparam int CNT_W = $clog2(LAT_S + 1);
    localparam int SUM_W = OUT_W + 1;
    localparam int ENT_W = DIG_W + 1;
    localparam logic [SUM_W-1:0] CODE_MAX = {1'b0, {OUT_W{1'b1}}};

    logic [DIG_W*NSTAGE-1:0] aligned_dig;
    logic [NSTAGE-1:0]       aligned_bad;
    logic [SUM_W-1:0]        sum_w;
    logic [CNT_W-1:0]        fill_q;
    logic                    fill_done;

    generate
        for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
            logic [CMP_W-1:0] raw;
            digit_t           dig;
            logic             bad;
            logic [ENT_W-1:0] ent_q;

            if (i < NRED) begin : g_red
                assign raw = stg_cmp_i[CMP_W*i +: CMP_W];
            end else begin : g_last
                assign raw = flash_i;
            end

            pipe_digit_decode #(.IS_FLASH(i == NRED)) u_dec (
                .raw_i (raw),
                .dig_o (dig),
                .bad_o (bad)
            );

            // Stage i+1 needs NSTAGE-i registers to meet the final stage.
            pipe_align_delay #(.W(ENT_W), .DEPTH(NSTAGE - i)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   ({bad, dig}),
                .q_o   (ent_q)
            );

            assign aligned_dig[DIG_W*i +: DIG_W] = ent_q[DIG_W-1:0];
            assign aligned_bad[i]                = ent_q[DIG_W];
        end
    endgenerate

    pipe_overlap_sum #(.NSTAGE(NSTAGE)) u_sum (
        .dig_i (aligned_dig),
        .sum_o (sum_w)
    );

    assign fill_done = (fill_q == CNT_W'(LAT_S));

    // Count sampling edges since reset until the first sample can arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (samp_en_i && !fill_done) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Output latch: load on sampling ticks once the pipeline holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else if (samp_en_i && fill_done) begin
            code_o  <= sum_w[OUT_W-1:0];
            valid_o <= 1'b1;
            err_o   <= |aligned_bad;
        end
    end

    // R3
    alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en_i |=> !samp_en_i);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en_i |=> ($stable(code_o) && $stable(err_o) && $stable(valid_o)));

    // R6
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w <= CODE_MAX);
endmodule

// File: tb/pipe_adc_corrector_test.sv
// Self-checking bench: builds per-sample stage patterns (directed, a ramp
// through an offset-laden residue model, random), staggers them onto the
// stage buses, and compares the outputs to a behavioural model every tick.
module pipe_adc_corrector_test;
    localparam int NSTAGE = 9;
    localparam int NRED   = NSTAGE - 1;
    localparam int N_DIR  = 8;
    localparam int N_RAMP = 4096;
    localparam int N_RND  = 256;
    localparam int NSAMP  = N_DIR + N_RAMP + N_RND;
    localparam longint ONE = 64'd1 << 20;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             samp_en_i;
    logic [2*NRED-1:0] stg_cmp_i;
    logic [1:0]       flash_i;
    logic [NSTAGE:0]  code_o;
    logic             valid_o;
    logic             err_o;

    int pat [NSAMP][NSTAGE];
    int exp_code [NSAMP];
    bit exp_err [NSAMP];
    bit hit [1024];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pipe_adc_corrector #(.NSTAGE(NSTAGE)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en_i (samp_en_i),
        .stg_cmp_i (stg_cmp_i),
        .flash_i   (flash_i),
        .code_o    (code_o),
        .valid_o   (valid_o),
        .err_o     (err_o)
    );

    function automatic int dig_of(int p, int i);
        if (i == NSTAGE - 1) return p;
        case (p)
            0: return 0;
            1: return 1;
            3: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int thermo_of(int d);
        return (d == 0) ? 0 : (d == 1) ? 1 : 3;
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic build();
        longint off_lo [NRED];
        longint off_hi [NRED];
        int lim;
        lim = (1 << 18) - 1;
        for (int i = 0; i < NRED; i++) begin
            off_lo[i] = longint'($urandom_range(0, 2 * lim)) - lim;
            off_hi[i] = longint'($urandom_range(0, 2 * lim)) - lim;
        end
        for (int n = 0; n < N_DIR; n++)
            for (int i = 0; i < NSTAGE; i++) pat[n][i] = 0;
        // n0 all zero -> 0 (R1); n1 all full -> 1023 (R1, R2)
        for (int i = 0; i < NRED; i++) pat[1][i] = 3;
        pat[1][NRED] = 3;
        // n2 all middle, flash 0 -> 510; n3 all middle, flash 2 -> 512
        for (int i = 0; i < NRED; i++) begin pat[2][i] = 1; pat[3][i] = 1; end
        pat[3][NRED] = 2;
        // n4 first stage full only -> 512 (R2)
        pat[4][0] = 3;
        // n5 first stage impossible -> 256 with error (R5)
        pat[5][0] = 2;
        // n6 stage 8 impossible, flash 1 -> 3 with error (R5)
        pat[6][NRED-1] = 2;
        pat[6][NRED] = 1;
        // n7 flash 3 only -> 3
        pat[7][NRED] = 3;
        // Ramp through an ideal residue pipeline with offset thresholds (R8).
        for (int r = 0; r < N_RAMP; r++) begin
            longint x;
            int d;
            x = -ONE + longint'(r) * 512;
            for (int i = 0; i < NRED; i++) begin
                if (x >= ONE / 4 + off_hi[i]) d = 2;
                else if (x >= -(ONE / 4) + off_lo[i]) d = 1;
                else d = 0;
                pat[N_DIR + r][i] = thermo_of(d);
                x = 2 * x - longint'(d - 1) * ONE;
            end
            if (x < -(ONE / 2)) d = 0;
            else if (x < 0) d = 1;
            else if (x < ONE / 2) d = 2;
            else d = 3;
            pat[N_DIR + r][NRED] = d;
        end
        // Random patterns, impossible ones included but rarer.
        for (int n = N_DIR + N_RAMP; n < NSAMP; n++) begin
            for (int i = 0; i < NRED; i++) begin
                int u;
                u = int'($urandom_range(0, 7));
                pat[n][i] = (u < 3) ? 0 : (u < 6) ? 1 : (u == 6) ? 3 : 2;
            end
            pat[n][NRED] = int'($urandom_range(0, 3));
        end
        for (int n = 0; n < NSAMP; n++) begin
            int s;
            bit e;
            s = 0;
            e = 1'b0;
            for (int i = 0; i < NSTAGE; i++) begin
                s += dig_of(pat[n][i], i) << (NSTAGE - 1 - i);
                if (i < NRED && pat[n][i] == 2) e = 1'b1;
            end
            exp_code[n] = s;
            exp_err[n] = e;
        end
    endtask

    function automatic string tag_of(int n);
        if (n < 4) return "R1";
        if (n < N_DIR) return "R2";
        if (n < N_DIR + N_RAMP) return "R2";
        return "R3";
    endfunction

    // Drive the inputs that the design captures at edge t.
    task automatic drive(input int t);
        logic [2*NRED-1:0] v;
        logic [1:0] f;
        for (int i = 0; i < NSTAGE; i++) begin
            int s;
            int val;
            s = t - (i + 1);
            if (s >= 0 && s % 2 == 0 && s / 2 < NSAMP) val = pat[s / 2][i];
            else val = int'($urandom_range(0, 3));
            if (i < NRED) v[2*i +: 2] = 2'(val);
            else f = 2'(val);
        end
        samp_en_i = (t % 2 == 0);
        stg_cmp_i = v;
        flash_i = f;
    endtask

    initial begin
        int t_last;
        int e_code;
        int e_valid;
        int e_err;
        int prev;
        int missing;
        build();
        rst_n = 1'b0;
        samp_en_i = 1'b0;
        stg_cmp_i = '0;
        flash_i = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7", "reset code", int'(code_o), 0);
        check("R7", "reset valid", int'(valid_o), 0);
        check("R7", "reset err", int'(err_o), 0);
        rst_n = 1'b1;
        drive(0);
        e_code = 0; e_valid = 0; e_err = 0; prev = -1;
        t_last = 2 * (NSAMP - 1) + 10;
        for (int t = 0; t <= t_last; t++) begin
            string tg;
            @(posedge clk);
            @(negedge clk);
            tg = (t % 2 == 1) ? "R4" : "R3";
            if (t % 2 == 0 && t >= 10) begin
                int n;
                n = (t - 10) / 2;
                e_code = exp_code[n];
                e_err = int'(exp_err[n]);
                e_valid = 1;
                tg = tag_of(n);
                if (n >= N_DIR && n < N_DIR + N_RAMP) begin
                    if (prev >= 0) begin
                        n_chk++;
                        if (int'(code_o) < prev) begin
                            n_fail++;
                            $display("FAIL R8 ramp not monotonic: actual %0d expected >= %0d",
                                     code_o, prev);
                        end
                    end
                    prev = int'(code_o);
                    hit[code_o] = 1'b1;
                end
            end
            check(tg, "code", int'(code_o), e_code);
            check((t % 2 == 1) ? "R4" : "R5", "err flag", int'(err_o), e_err);
            check((t % 2 == 1) ? "R4" : "R6", "valid flag", int'(valid_o), e_valid);
            if (t < t_last) drive(t + 1);
        end
        missing = 0;
        for (int c = 0; c < 1024; c++) if (!hit[c]) missing++;
        check("R8", "missing ramp codes", missing, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual run still busy, expected finished");
            summary();
            $finish;
        end
    end
endmodule